// File: doc/BRIEF.md
# I2C Clock Period Generator

This block produces the SCL waveform timing for an I2C master. It divides the peripheral clock by a programmable prescaler to obtain an internal tick, then counts ticks to form a low phase and a high phase for each bit. The master engine holds `run` high for the duration of a transfer and receives a one-cycle strobe at the end of each low phase and at the end of each high phase. It uses these strobes to move SDA and to sample it. When `run` is low at the end of a high phase, the block goes back to idle and leaves SCL released.

Each bit period is a fixed 20 ticks plus 8 ticks for each step of a 6-bit period field. The block splits this count between the two phases. A phase's tick count starts only once the synchronised SCL line shows the level that phase drives or releases. Because of this, slow rise times and target clock stretching lengthen the period without any extra logic. At the start of a transfer, the block holds SCL released for a programmable number of clock cycles before the first low phase. This lead time lets SDA settle ahead of the first clock edge.

Software may write the timing settings at any time. The block copies them into its working set only when a transfer starts, so a write made during a transfer has no effect until the next START.

Top module: `scl_rate_gen`

## Requirements
- R1: After reset, `scl_pull`, `busy`, `lo_end` and `hi_end` are all 0.
- R2: A write on `cfg_wr` takes the prescale value from `cfg_data[2:0]` and the period field (0 to 63) from `cfg_data[8:3]`. A write on `lead_wr` takes a 4-bit lead value from `lead_data`.
- R3: While a phase counts, the internal tick occurs once every (prescale + 1) clock cycles. Each tick counts as one unit of phase time.
- R4: The phase tick counts are computed from T = 20 + 8 × period. The high phase is floor(T/2) ticks and the low phase is T − floor(T/2) ticks.
- R5: In a low phase, `scl_pull` stays 1 for SYNC_STAGES + low_ticks × (prescale + 1) cycles. Counting does not start while the synchronised SCL still reads high.
- R6: In a high phase, `scl_pull` stays 0 for X + SYNC_STAGES + high_ticks × (prescale + 1) cycles. X is the number of cycles the line is held low by others after release, and counting waits while SCL reads low.
- R7: A START occurs when `run` is seen high while idle. It raises `busy` and keeps SCL released for exactly lead + 2 cycles before the first low phase.
- R8: The working timing settings are loaded only at START. A write made while `busy` is high does not change the transfer in progress and applies from the next START.
- R9: When `run` is low at the end of a high phase, the block returns to idle with `busy` 0 and `scl_pull` 0.
- R10: `lo_end` and `hi_end` are single-cycle strobes and are never high together. There is exactly one `lo_end` per low phase and one `hi_end` per high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the divider settings |
| cfg_data | input | 9 | Prescale in [2:0], period field in [8:3] |
| lead_wr | input | 1 | Write strobe for the first-bit lead time |
| lead_data | input | 4 | Lead value; lead time is value + 2 cycles |
| run | input | 1 | Transfer request from the master engine |
| scl_in | input | 1 | Observed SCL line level (asynchronous) |
| scl_pull | output | 1 | 1 drives SCL low, 0 releases it |
| busy | output | 1 | High from START until return to idle |
| lo_end | output | 1 | One-cycle strobe at the end of a low phase |
| hi_end | output | 1 | One-cycle strobe at the end of a high phase |

## Verification
The in-line assertions check, on every cycle, several properties that hold at all times: no tick is produced while a phase waits for the line to reach its level, the prescaler and phase counters stay below their limits, the lead counter stays within its window, the working settings stay frozen while busy, SCL is released when idle, and the strobes are single-cycle and exclusive. Only the bench scenarios can show that the measured phase lengths match the tick arithmetic for each prescale and period value, that stretching adds exactly the held cycles, that the lead time has the right length, and that a write made mid-transfer takes effect only on the following transfer.

// File: rtl/scl_rg_pkg.sv
package scl_rg_pkg;

    parameter int PRE_W      = 3;
    parameter int PER_W      = 6;
    parameter int LEAD_W     = 4;
    parameter int BASE_TICKS = 20;
    parameter int STEP_TICKS = 8;

    localparam int CFG_W     = PRE_W + PER_W;
    localparam int MAX_TOTAL = BASE_TICKS + STEP_TICKS * ((1 << PER_W) - 1);
    localparam int CNT_W     = $clog2(MAX_TOTAL + 1);
    localparam int LCNT_W    = LEAD_W + 1;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LEAD,
        ST_LOW,
        ST_HIGH
    } phase_e;

    typedef struct packed {
        logic [PRE_W-1:0]  pre;
        logic [PER_W-1:0]  per;
        logic [LEAD_W-1:0] lead;
    } timing_t;

    typedef struct packed {
        phase_e            st;
        timing_t           pend;
        timing_t           act;
        logic [LCNT_W-1:0] lead_cnt;
        logic              lo_end;
        logic              hi_end;
    } gen_state_t;

    function automatic logic [CNT_W-1:0] period_ticks(input logic [PER_W-1:0] per);
        int total;
        total = BASE_TICKS + STEP_TICKS * int'(per);
        return CNT_W'(total);
    endfunction

    // High phase takes the lower half; an odd leftover lands in the low phase.
    function automatic logic [CNT_W-1:0] high_ticks(input logic [PER_W-1:0] per);
        return period_ticks(per) >> 1;
    endfunction

    function automatic logic [CNT_W-1:0] low_ticks(input logic [PER_W-1:0] per);
        return period_ticks(per) - (period_ticks(per) >> 1);
    endfunction

endpackage

// File: rtl/scl_rg_sync.sv
module scl_rg_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] sh_d, sh_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb sh_d = din;
        end else begin : g_many
            always_comb sh_d = {sh_q[STAGES-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= {STAGES{RST_VAL}};
        else        sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];

endmodule

// File: rtl/scl_rg_prescale.sv
module scl_rg_prescale
    import scl_rg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [PRE_W-1:0] pre,
    output logic             tick
);

    logic [PRE_W-1:0] pc_d, pc_q;

    assign tick = en && (pc_q == pre);

    always_comb begin
        pc_d = pc_q;
        if (!en)       pc_d = '0;
        else if (tick) pc_d = '0;
        else           pc_d = pc_q + PRE_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_d;
    end

    AST_PRE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> (pc_q <= pre)); // R3

endmodule

// File: rtl/scl_rg_phase.sv
module scl_rg_phase
    import scl_rg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             tick,
    input  logic [CNT_W-1:0] len,
    output logic             done
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    assign done = !clear && tick && (cnt_q == len - CNT_W'(1));

    always_comb begin
        cnt_d = cnt_q;
        if (clear || done) cnt_d = '0;
        else if (tick)     cnt_d = cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_CNT_BELOW_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |-> (cnt_q < len)); // R4

endmodule

// File: rtl/scl_rate_gen.sv
module scl_rate_gen
    import scl_rg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [CFG_W-1:0]  cfg_data,
    input  logic              lead_wr,
    input  logic [LEAD_W-1:0] lead_data,
    input  logic              run,
    input  logic              scl_in,
    output logic              scl_pull,
    output logic              busy,
    output logic              lo_end,
    output logic              hi_end
);

    gen_state_t       q, d;
    logic             line_hi;
    logic             cnt_en;
    logic             tick;
    logic             ph_done;
    logic             ph_clear;
    logic [CNT_W-1:0] ph_len;

    scl_rg_sync #(
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b1)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (scl_in),
        .dout  (line_hi)
    );

    // Counting only once the line shows the level of the current phase.
    assign cnt_en   = ((q.st == ST_LOW) && !line_hi) || ((q.st == ST_HIGH) && line_hi);
    assign ph_clear = (q.st != ST_LOW) && (q.st != ST_HIGH);
    assign ph_len   = (q.st == ST_LOW) ? low_ticks(q.act.per) : high_ticks(q.act.per);

    scl_rg_prescale u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (cnt_en),
        .pre   (q.act.pre),
        .tick  (tick)
    );

    scl_rg_phase u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (ph_clear),
        .tick  (tick),
        .len   (ph_len),
        .done  (ph_done)
    );

    always_comb begin
        d        = q;
        d.lo_end = 1'b0;
        d.hi_end = 1'b0;

        if (cfg_wr) begin
            d.pend.pre = cfg_data[PRE_W-1:0];
            d.pend.per = cfg_data[CFG_W-1:PRE_W];
        end
        if (lead_wr) d.pend.lead = lead_data;

        unique case (q.st)
            ST_IDLE: begin
                if (run) begin
                    d.act      = q.pend;
                    d.lead_cnt = '0;
                    d.st       = ST_LEAD;
                end
            end
            ST_LEAD: begin
                if (q.lead_cnt == LCNT_W'(q.act.lead) + LCNT_W'(1)) begin
                    d.st = ST_LOW;
                end else begin
                    d.lead_cnt = q.lead_cnt + LCNT_W'(1);
                end
            end
            ST_LOW: begin
                if (ph_done) begin
                    d.lo_end = 1'b1;
                    d.st     = ST_HIGH;
                end
            end
            ST_HIGH: begin
                if (ph_done) begin
                    d.hi_end = 1'b1;
                    d.st     = run ? ST_LOW : ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q          <= '0;
            q.st       <= ST_IDLE;
            q.pend.per <= '0;
        end else begin
            q <= d;
        end
    end

    assign scl_pull = (q.st == ST_LOW);
    assign busy     = (q.st != ST_IDLE);
    assign lo_end   = q.lo_end;
    assign hi_end   = q.hi_end;

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(lo_end && hi_end)); // R10

    AST_LO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        lo_end |=> !lo_end); // R10

    AST_HI_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        hi_end |=> !hi_end); // R10

    AST_ACT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(q.act)); // R8

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !scl_pull); // R9

    AST_LOW_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.st == ST_LOW) && line_hi) |-> !tick); // R5

    AST_HIGH_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.st == ST_HIGH) && !line_hi) |-> !tick); // R6

    AST_LEAD_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_LEAD) |-> (q.lead_cnt <= LCNT_W'(q.act.lead) + LCNT_W'(1))); // R7

endmodule

// File: tb/scl_rate_gen_tb.sv
module scl_rate_gen_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int SYNC       = 2;
    localparam int WATCHDOG   = 100000;

    localparam int K_LEAD = 0;
    localparam int K_LOW  = 1;
    localparam int K_HIGH = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [8:0] cfg_data = '0;
    logic       lead_wr = 1'b0;
    logic [3:0] lead_data = '0;
    logic       run = 1'b0;
    logic       stretch = 1'b0;
    logic       scl_in;
    logic       scl_pull, busy, lo_end, hi_end;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    int exp_kind[$];
    int exp_len[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    // Open-drain line: low when the block pulls or a target stretches.
    assign scl_in = !(scl_pull || stretch);

    scl_rate_gen #(.SYNC_STAGES(SYNC)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_data  (cfg_data),
        .lead_wr   (lead_wr),
        .lead_data (lead_data),
        .run       (run),
        .scl_in    (scl_in),
        .scl_pull  (scl_pull),
        .busy      (busy),
        .lo_end    (lo_end),
        .hi_end    (hi_end)
    );

    function automatic string kind_tag(input int k);
        if (k == K_LEAD) return "R7 lead";
        if (k == K_LOW)  return "R5 low";
        return "R6 high";
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic push_exp(input int k, input int len);
        exp_kind.push_back(k);
        exp_len.push_back(len);
    endtask

    task automatic got(input int k, input int len);
        int ek, el;
        if (exp_kind.size() == 0) begin
            check(1'b0, {"R10 unexpected ", kind_tag(k)}, len, -1);
        end else begin
            ek = exp_kind.pop_front();
            el = exp_len.pop_front();
            check(ek == k, "R10 phase order", k, ek);
            check(el == len, kind_tag(k), len, el);
        end
    endtask

    // Monitor: measures phase lengths in cycles, sampled at negedge.
    initial begin
        int lowcnt = 0;
        int highcnt = 0;
        bit first = 1'b1;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (lo_end) begin got(K_LOW, lowcnt);  lowcnt = 0; end
                if (hi_end) begin got(K_HIGH, highcnt); highcnt = 0; end
                if (!busy) begin
                    lowcnt = 0; highcnt = 0; first = 1'b1;
                end else if (scl_pull) begin
                    if (first) begin
                        got(K_LEAD, highcnt);
                        highcnt = 0;
                        first = 1'b0;
                    end
                    lowcnt++;
                end else begin
                    highcnt++;
                end
            end
        end
    end

    task automatic set_timing(input logic [2:0] pre, input logic [5:0] per, input logic [3:0] lead);
        @(negedge clk);
        cfg_wr    = 1'b1;
        cfg_data  = {per, pre};   // R2: prescale in [2:0], period in [8:3]
        lead_wr   = 1'b1;
        lead_data = lead;
        @(negedge clk);
        cfg_wr  = 1'b0;
        lead_wr = 1'b0;
    endtask

    // Driver: pushes expected phase lengths (R3, R4), then runs n bit periods.
    task automatic xfer(input int pre, input int per, input int lead, input int n, input int sx);
        int total, hi_t, lo_t, lo_c, hi_c, seen, guard;
        bit armed;
        total = 20 + 8 * per;
        hi_t  = total / 2;
        lo_t  = total - hi_t;
        lo_c  = SYNC + lo_t * (pre + 1);
        hi_c  = SYNC + hi_t * (pre + 1);
        push_exp(K_LEAD, lead + 2);
        for (int i = 0; i < n; i++) begin
            push_exp(K_LOW, lo_c);
            push_exp(K_HIGH, (i == 0) ? hi_c + sx : hi_c);
        end
        @(negedge clk);
        run   = 1'b1;
        seen  = 0;
        armed = 1'b0;
        while (seen < n) begin
            @(negedge clk);
            if (sx > 0 && !armed && scl_pull) begin
                stretch = 1'b1;
                armed   = 1'b1;
            end
            if (lo_end) begin
                seen++;
                if (seen == n) run = 1'b0;
                if (seen == 1 && sx > 0) begin
                    repeat (sx) @(negedge clk);
                    stretch = 1'b0;
                end
            end
        end
        guard = 0;
        while (busy && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        check(!busy && !scl_pull, "R9 idle after stop", {busy, scl_pull}, 0);
        repeat (3) @(negedge clk);
        check(!scl_pull && !busy, "R9 stays idle", {busy, scl_pull}, 0);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: got %0d expected %0d", WATCHDOG, 0);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(scl_pull == 1'b0, "R1 scl_pull", scl_pull, 0);
        check(busy == 1'b0,     "R1 busy",     busy, 0);
        check(lo_end == 1'b0,   "R1 lo_end",   lo_end, 0);
        check(hi_end == 1'b0,   "R1 hi_end",   hi_end, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Fastest setting, longest lead (R7: 15 -> 17 cycles)
        set_timing(3'd0, 6'd0, 4'd15);
        xfer(0, 0, 15, 2, 0);

        // R3: prescale 3 stretches each tick to four cycles
        set_timing(3'd3, 6'd5, 4'd0);
        xfer(3, 5, 0, 1, 0);

        // R2 R4: top of both fields
        set_timing(3'd7, 6'd63, 4'd4);
        xfer(7, 63, 4, 1, 0);

        // R6: target holds SCL low for 25 cycles after release
        set_timing(3'd1, 6'd2, 4'd1);
        xfer(1, 2, 1, 2, 25);

        // R8: write during a transfer leaves it unchanged
        set_timing(3'd0, 6'd1, 4'd2);
        fork
            xfer(0, 1, 2, 3, 0);
            begin
                repeat (30) @(negedge clk);
                check(busy == 1'b1, "R8 write lands mid-transfer", busy, 1);
                cfg_wr    = 1'b1;
                cfg_data  = {6'd3, 3'd0};
                lead_wr   = 1'b1;
                lead_data = 4'd6;
                @(negedge clk);
                cfg_wr  = 1'b0;
                lead_wr = 1'b0;
            end
        join
        // R8: the next START picks up the new values
        xfer(0, 3, 6, 1, 0);

        repeat (5) @(negedge clk);
        check(exp_kind.size() == 0, "R10 all phases seen", exp_kind.size(), 0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule